// File: doc/BRIEF.md
# Decimal-Programmed Clock Divider

This block divides its input clock by a whole number between 1 and 3999. The ratio arrives as four binary-coded decimal digits, so a bank of rotary decimal switches can drive it directly. Internally the count is kept as a chain of decimal down-counters, with a borrow passed from the units digit upward. The block produces two outputs: a single-cycle terminal pulse once per period, and a divided clock that is high for the first half of each period. The internal counter stages are not brought out.

A polarity select allows switch banks that rely on pull-ups and pull a line to ground for a zero. The ratio word is sampled only when the counter reloads, so the ratio can be changed while the divider runs without corrupting the period in progress. A word that contains a non-decimal digit is ignored, and the last good ratio stays in force. A word of zero acts as a ratio of one.

Top module: `bcd_divn`

## Requirements
- R1: Reset clears the count to the all-zero state and the held ratio to 1. In the first cycle after reset `tc_o` is 1 and `div_o` is 0, and the ratio word is sampled at the first clock edge.
- R2: With a valid ratio N, `tc_o` is high for exactly one clock in every N clocks. When N is 1 it stays high.
- R3: Bit positions of `ratio_i`: [13:12] hold the thousands digit (0 to 3), [11:8] hundreds, [7:4] tens and [3:0] units. For example, 14'b00_1000_1001_0110 selects 896 and 14'b01_0000_0111_1001 selects 1079.
- R4: Within each period of N clocks, `div_o` is high for the first floor(N/2) clocks and low for the rest. It is low in the cycle where `tc_o` is high.
- R5: When `pol_n_i` is 0, every bit of `ratio_i` is inverted before it is decoded. When `pol_n_i` is 1, the bits are used as they are.
- R6: A decoded word whose hundreds, tens or units digit is greater than 9 is ignored at reload, and the previously held ratio is used again.
- R7: A decoded word whose value is zero is treated as a ratio of 1.
- R8: `ratio_i` and `pol_n_i` are sampled only at the clock edge that ends a `tc_o` cycle. Changes at any other time have no effect on the period in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock to be divided |
| rst_i | input | 1 | Synchronous reset, active high |
| pol_n_i | input | 1 | 0: invert the ratio word before decoding (pulled-up switches) |
| ratio_i | input | 14 | Ratio as four BCD digits |
| tc_o | output | 1 | Terminal-count pulse, one clock wide |
| div_o | output | 1 | Divided clock, high for the first half of each period |

## Verification
Random small ratios, with the word sometimes changed in the middle of a period, show whether the ratio is taken only at reload and whether the half-period threshold is right for both odd and even N. The words for 896 and 1079, and a full-scale 3999, are measured from one pulse to the next. These runs expose borrow faults between digits that small ratios never reach. Inverted-polarity words, words with digits from 10 to 15, and an all-zero word separate the decode paths from one another. One of the inverted words is the 1079 pattern, so that the inversion is confirmed on a real ratio.

// File: rtl/bcd_divn_pkg.sv
package bcd_divn_pkg;
    typedef logic [3:0] bcd_digit_t;
    localparam bcd_digit_t DIGIT_MAX = 4'd9;

    typedef struct packed {
        bcd_digit_t val;
    } digit_state_t;
endpackage

// File: rtl/bcd_digit_cnt.sv
module bcd_digit_cnt
    import bcd_divn_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       load_i,
    input  bcd_digit_t load_val_i,
    input  logic       dec_i,
    output bcd_digit_t val_o
);
    digit_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.val = load_val_i;
        end else if (dec_i) begin
            if (st_q.val == 4'd0) st_d.val = DIGIT_MAX;
            else                  st_d.val = st_q.val - 4'd1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign val_o = st_q.val;

    // Every counting digit stays within the decimal range.
    assert_digit_range_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        st_q.val <= DIGIT_MAX);
endmodule

// File: rtl/bcd_ratio_ctl.sv
module bcd_ratio_ctl
    import bcd_divn_pkg::*;
#(
    parameter int DIGITS   = 4,
    parameter int TOP_BITS = 2,
    localparam int RAW_W   = TOP_BITS + 4 * (DIGITS - 1),
    localparam int CNT_W   = 4 * DIGITS
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             reload_i,
    input  logic             pol_n_i,
    input  logic [RAW_W-1:0] ratio_i,
    output logic [CNT_W-1:0] load_o,
    output logic [CNT_W-1:0] half_o
);
    typedef struct packed {
        logic [CNT_W-1:0] ratio;
        logic [CNT_W-1:0] half;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    function automatic logic [CNT_W-1:0] bcd_minus1(input logic [CNT_W-1:0] x);
        logic [CNT_W-1:0] r;
        logic             brw;
        r   = x;
        brw = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            if (brw) begin
                if (x[4*i +: 4] == 4'd0) begin
                    r[4*i +: 4] = DIGIT_MAX;
                end else begin
                    r[4*i +: 4] = x[4*i +: 4] - 4'd1;
                    brw = 1'b0;
                end
            end
        end
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] bcd_halve(input logic [CNT_W-1:0] x);
        logic [CNT_W-1:0] r;
        logic             rem;
        logic [4:0]       v;
        r   = '0;
        rem = 1'b0;
        for (int i = DIGITS - 1; i >= 0; i--) begin
            v = (rem ? 5'd10 : 5'd0) + {1'b0, x[4*i +: 4]};
            r[4*i +: 4] = v[4:1];
            rem = v[0];
        end
        return r;
    endfunction

    logic [RAW_W-1:0] word;
    logic [CNT_W-1:0] cand;
    logic [CNT_W-1:0] eff;
    logic [CNT_W-1:0] eff_m1;
    logic             cand_ok;

    always_comb begin
        word = pol_n_i ? ratio_i : ~ratio_i;
        cand = '0;
        for (int i = 0; i < DIGITS - 1; i++) begin
            cand[4*i +: 4] = word[4*i +: 4];
        end
        cand[CNT_W-1 -: 4] = 4'(word[RAW_W-1 -: TOP_BITS]);

        cand_ok = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            if (cand[4*i +: 4] > DIGIT_MAX) cand_ok = 1'b0;
        end

        if (!cand_ok)          eff = st_q.ratio;
        else if (cand == '0)   eff = CNT_W'(1);
        else                   eff = cand;

        eff_m1 = bcd_minus1(eff);

        st_d = st_q;
        if (reload_i) begin
            st_d.ratio = eff;
            st_d.half  = bcd_halve(eff_m1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q.ratio <= CNT_W'(1);
            st_q.half  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o = eff_m1;
    assign half_o = st_q.half;

    // The held ratio only moves at a reload.
    assert_hold_between_reloads_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !reload_i |=> $stable(st_q.ratio));

    // The held ratio is never zero and never has a non-decimal digit (R6, R7).
    assert_held_ratio_valid_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.ratio != '0) && (st_q.ratio[3:0] <= DIGIT_MAX)
        && (st_q.ratio[7:4] <= DIGIT_MAX) && (st_q.ratio[11:8] <= DIGIT_MAX));
endmodule

// File: rtl/bcd_divn.sv
module bcd_divn
    import bcd_divn_pkg::*;
#(
    parameter int DIGITS   = 4,
    parameter int TOP_BITS = 2,
    localparam int RAW_W   = TOP_BITS + 4 * (DIGITS - 1),
    localparam int CNT_W   = 4 * DIGITS
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             pol_n_i,
    input  logic [RAW_W-1:0] ratio_i,
    output logic             tc_o,
    output logic             div_o
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] half_q;
    logic [DIGITS-1:0] dec;
    logic             reload;

    assign reload = (count_q == '0);

    bcd_ratio_ctl #(
        .DIGITS  (DIGITS),
        .TOP_BITS(TOP_BITS)
    ) u_ctl (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .reload_i(reload),
        .pol_n_i (pol_n_i),
        .ratio_i (ratio_i),
        .load_o  (load_val),
        .half_o  (half_q)
    );

    assign dec[0] = ~reload;

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        if (g > 0) begin : g_borrow
            assign dec[g] = dec[g-1] & (count_q[4*(g-1) +: 4] == 4'd0);
        end
        bcd_digit_cnt u_digit (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .load_i    (reload),
            .load_val_i(load_val[4*g +: 4]),
            .dec_i     (dec[g]),
            .val_o     (count_q[4*g +: 4])
        );
    end

    assign tc_o  = reload;
    assign div_o = (count_q > half_q);

    // A pulse is followed by a quiet cycle unless the next period is one clock.
    assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (tc_o && (load_val != '0)) |=> !tc_o);

    // The divided clock is low in the terminal cycle.
    assert_div_low_at_tc_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        tc_o |-> !div_o);

    // Leaving reset, the block starts in the terminal state.
    assert_reset_state_R1: assert property (@(posedge clk_i)
        $fell(rst_i) |-> tc_o && !div_o);
endmodule

// File: tb/bcd_divn_test.sv
module bcd_divn_test;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pol_n = 1'b1;
    logic [13:0] ratio = 14'd0;
    logic        tc, dv;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;
    string tag = "R2";

    int m_cnt = 0, m_held = 1, m_per = 1;

    bcd_divn uut (
        .clk_i  (clk),
        .rst_i  (rst),
        .pol_n_i(pol_n),
        .ratio_i(ratio),
        .tc_o   (tc),
        .div_o  (dv)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [13:0] enc(input int n);
        return {2'(n / 1000), 4'((n / 100) % 10), 4'((n / 10) % 10), 4'(n % 10)};
    endfunction

    function automatic int decode(input logic [13:0] w, input logic p, input int held);
        logic [13:0] x;
        int v;
        x = p ? w : ~w;
        if (x[11:8] > 9 || x[7:4] > 9 || x[3:0] > 9) return held;
        v = int'(x[13:12]) * 1000 + int'(x[11:8]) * 100 + int'(x[7:4]) * 10 + int'(x[3:0]);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // One clock: model the edge, then compare at the falling edge.
    task automatic tick();
        @(posedge clk);
        if (m_cnt == 0) begin
            m_held = decode(ratio, pol_n, m_held);
            m_per  = m_held;
            m_cnt  = m_held - 1;
        end else begin
            m_cnt--;
        end
        @(negedge clk);
        cycles++;
        check({tag, " tc"}, int'(tc), int'(m_cnt == 0));
        check({tag, " div R4"}, int'(dv), int'((m_per - 1 - m_cnt) < (m_per / 2)));
    endtask

    task automatic measure(input logic [13:0] w, input logic p, input int exp, input string req);
        int n;
        ratio = w;
        pol_n = p;
        while (!tc) tick();
        n = 0;
        do begin
            tick();
            n++;
        end while (!tc && n < 5000);
        check({req, " period"}, n, exp);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=finish", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd7731);
        ratio = 14'h3FFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: terminal state out of reset, held ratio 1 (invalid word at first edge)
        tag = "R1";
        check("R1 tc", int'(tc), 1);
        check("R1 div", int'(dv), 0);
        tick();
        check("R1 period one", int'(tc), 1);

        // R3 / R5: directed ratios measured pulse to pulse
        tag = "R3";
        measure(14'b00_1000_1001_0110, 1'b1, 896, "R3 896");
        measure(14'b01_0000_0111_1001, 1'b1, 1079, "R3 1079");
        tag = "R5";
        measure(~14'b01_0000_0111_1001, 1'b0, 1079, "R5 inverted 1079");
        measure(~enc(7), 1'b0, 7, "R5 inverted 7");
        tag = "R2";
        measure(enc(3999), 1'b1, 3999, "R2 full scale");
        measure(enc(1), 1'b1, 1, "R2 ratio one");
        measure(enc(2), 1'b1, 2, "R2 ratio two");

        // R7: zero word behaves as one
        tag = "R7";
        measure(14'd0, 1'b1, 1, "R7 zero");
        measure(~14'd0, 1'b0, 1, "R7 inverted zero");

        // R6: invalid digits keep the previous ratio
        tag = "R6";
        measure(enc(13), 1'b1, 13, "R6 setup");
        measure(14'b00_0000_1010_0101, 1'b1, 13, "R6 tens 10");
        measure(14'b01_1111_0000_0000, 1'b1, 13, "R6 hundreds 15");
        measure(14'b00_0000_0000_1100, 1'b1, 13, "R6 units 12");

        // R8 and random mix: word changes at arbitrary cycles
        tag = "R8";
        for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(0, 9) == 0) begin
                int sel;
                sel = $urandom_range(0, 9);
                pol_n = ($urandom_range(0, 3) != 0);
                if (sel == 0) ratio = 14'($urandom);
                else if (sel == 1) ratio = pol_n ? 14'd0 : ~14'd0;
                else ratio = pol_n ? enc($urandom_range(1, 40)) : ~enc($urandom_range(1, 40));
            end
            tick();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule